// File: doc/BRIEF.md
# Fixed-Weight Combination Sequence Generator

This block streams every W-bit word that has exactly K ones, in strictly ascending numeric order. It does not count through all values and discard the ones with the wrong weight. Each successor comes from one combinational step. That step isolates the lowest set bit and adds it to the word, which carries the lowest run of ones one place up. It then counts the trailing zeros and shifts the leftover ones of that run back down to bit 0. A new word is therefore ready every cycle. The stream feeds basis configurations to a spin-lattice state enumerator, where a 40-bit word with 10 to 20 ones is typical.

A pulse on `start_i` samples the weight `k_i` and loads the smallest word of that weight. The consumer then takes words over a valid/ready handshake. The final word, which has the K top bits set, comes with `last_o`. Once that word is accepted, `valid_o` falls and `done_o` stays high until the next start.

Top module: `comb_seq_gen`

## Requirements
- R1: The first cycle after a start pulse, `valid_o` is high and `word_o` holds the K lowest bits set (bits K-1..0 are 1, all other bits are 0).
- R2: Every word presented with `valid_o` high has exactly K bits set.
- R3: Each accepted word that is not the last is followed by the next larger W-bit value of the same weight. No value of that weight is skipped.
- R4: A run produces exactly C(W,K) words. The final word has bits W-1..W-K set, and it is the only word presented with `last_o` high.
- R5: When the final word is accepted, `valid_o` falls and `done_o` rises on the next cycle. `done_o` then stays high and `valid_o` stays low until the next start.
- R6: While `valid_o` is high and `ready_i` is low, with no start pulse, `word_o` and `valid_o` keep their values into the next cycle.
- R7: With K=0 the run is a single all-zero word flagged last. With K=W the run is a single all-ones word flagged last.
- R8: A weight `k_i` greater than W is treated as W.
- R9: A start pulse while a run is in progress abandons that run and restarts from the first word of the newly sampled weight.
- R10: While reset is asserted and after it is released, `valid_o`, `done_o` and `last_o` are low and `word_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse: sample `k_i` and load the first word |
| k_i | input | $clog2(W+1) | Number of ones per word; values above W saturate to W |
| ready_i | input | 1 | Consumer can accept the presented word |
| valid_o | output | 1 | `word_o` holds a sequence member |
| word_o | output | W | Current word |
| last_o | output | 1 | Current word is the final one of the run |
| done_o | output | 1 | Run complete; stays high until the next start |

## Verification
A fault in the successor logic (a wrong shift count, a carry lost out of the top, a run repacked to the wrong place) appears at the first accepted word after the faulty step, as a value differing from the reference enumeration. It also desynchronises every later compare and the final word count. A state machine that leaves the running state too early or too late shows up at the end of the run: the `last_o` flag is wrong, the count differs from C(W,K), or `done_o` is late or missing. Backpressure faults show up one cycle after a stalled cycle, as a word that changed without a handshake.

// File: rtl/comb_seq_pkg.sv
package comb_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/comb_first.sv
// Mask with the k lowest bits set
module comb_first #(
  parameter int W  = 40,
  parameter int KW = $clog2(W + 1)
) (
  input  logic [KW-1:0] k_i,
  output logic [W-1:0]  mask_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mask_o[i] = (k_i > KW'(i));
  end
endmodule

// File: rtl/comb_tzc.sv
// Trailing zero count; zero_o flags an all-zero input
module comb_tzc #(
  parameter int W  = 40,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) cnt_o = CW'(i);
    end
  end
  assign zero_o = ~|vec_i;
endmodule

// File: rtl/comb_succ.sv
// Next larger word of equal weight, single cycle.
// final_o: no successor exists (carry out of the top, or empty word).
module comb_succ #(
  parameter int W = 40
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o,
  output logic         final_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  low_bit;
  logic [W-1:0]  sum;
  logic          carry;
  logic [W-1:0]  moved;
  logic [W-1:0]  refill;
  logic [CW-1:0] tz;
  logic          empty;
  logic [CW:0]   sh;

  comb_tzc #(.W(W), .CW(CW)) u_tzc (
    .vec_i  (cur_i),
    .cnt_o  (tz),
    .zero_o (empty)
  );

  assign low_bit      = cur_i & (~cur_i + 1'b1);
  assign {carry, sum} = {1'b0, cur_i} + {1'b0, low_bit};
  // bits of the lowest run plus the bit it carried into
  assign moved        = sum ^ cur_i;
  assign sh           = {1'b0, tz} + (CW + 1)'(2);
  assign refill       = moved >> sh;
  assign nxt_o        = sum | refill;
  assign final_o      = carry | empty;
endmodule

// File: rtl/comb_seq_gen.sv
module comb_seq_gen
  import comb_seq_pkg::*;
#(
  parameter int W = 40
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [$clog2(W+1)-1:0] k_i,
  input  logic                   ready_i,
  output logic                   valid_o,
  output logic [W-1:0]           word_o,
  output logic                   last_o,
  output logic                   done_o
);
  localparam int KW = $clog2(W + 1);

  seq_state_e    state_q;
  logic [W-1:0]  word_q;
  logic [KW-1:0] k_q;
  logic [KW-1:0] k_eff;
  logic [W-1:0]  first_word;
  logic [W-1:0]  next_word;
  logic          is_final;

  assign k_eff = (k_i > KW'(W)) ? KW'(W) : k_i;

  comb_first #(.W(W), .KW(KW)) u_first (
    .k_i    (k_eff),
    .mask_o (first_word)
  );

  comb_succ #(.W(W)) u_succ (
    .cur_i   (word_q),
    .nxt_o   (next_word),
    .final_o (is_final)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      k_q     <= '0;
    end else if (start_i) begin
      state_q <= ST_RUN;
      word_q  <= first_word;
      k_q     <= k_eff;
    end else if (state_q == ST_RUN && ready_i) begin
      if (is_final) state_q <= ST_DONE;
      else          word_q  <= next_word;
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_DONE);
  assign last_o  = valid_o & is_final;
  assign word_o  = word_q;
endmodule

// File: rtl/comb_seq_chk.sv
module comb_seq_chk #(
  parameter int W  = 40,
  parameter int KW = $clog2(W + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          ready_i,
  input logic          valid_o,
  input logic          done_o,
  input logic          last_o,
  input logic [W-1:0]  word_o,
  input logic [KW-1:0] k_q
);
  assert_start_loads_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && !done_o);

  assert_weight_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(word_o) == int'(k_q)));

  assert_ascending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !last_o && !start_i) |=> valid_o && (word_o > $past(word_o)));

  assert_last_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  assert_done_after_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && last_o && !start_i) |=> done_o && !valid_o);

  assert_done_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && valid_o));

  assert_done_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !start_i) |=> valid_o && $stable(word_o));
endmodule

bind comb_seq_gen comb_seq_chk #(.W(W), .KW(KW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .ready_i (ready_i),
  .valid_o (valid_o),
  .done_o  (done_o),
  .last_o  (last_o),
  .word_o  (word_o),
  .k_q     (k_q)
);

// File: tb/comb_seq_gen_bench.sv
module comb_seq_gen_bench;
  localparam int W       = 8;
  localparam int KW      = $clog2(W + 1);
  localparam int CLK_PER = 10;
  localparam int WDOG    = 100000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [KW-1:0] k_i = '0;
  logic          ready_i = 1'b0;
  logic          valid_o;
  logic [W-1:0]  word_o;
  logic          last_o;
  logic          done_o;

  int n_chk = 0;
  int n_fail = 0;
  int popped = 0;
  int cycles = 0;
  logic          hold = 1'b1;
  logic          full_rate = 1'b0;
  logic [15:0]   lfsr = 16'hACE1;
  logic          stall_seen = 1'b0;
  logic [W-1:0]  stall_word = '0;
  logic [W-1:0]  exp_q[$];

  comb_seq_gen #(.W(W)) u_comb_seq_gen (
    .clk_i, .rst_ni, .start_i, .k_i, .ready_i,
    .valid_o, .word_o, .last_o, .done_o
  );

  always #(CLK_PER/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int binom(input int n, input int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  // Driver: reference enumeration by counting and filtering
  task automatic push_expected(input int k);
    int ke = (k > W) ? W : k;
    exp_q.delete();
    for (int v = 0; v < (1 << W); v++)
      if ($countones(v[W-1:0]) == ke) exp_q.push_back(v[W-1:0]);
  endtask

  task automatic pulse_start(input int k);
    @(posedge clk_i); #1;
    start_i = 1'b1;
    k_i = KW'(k);
    @(posedge clk_i); #1;
    start_i = 1'b0;
  endtask

  // Ready pattern, changed just after each rising edge
  always begin
    @(posedge clk_i); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ready_i = hold ? 1'b0 : (full_rate | lfsr[0] | lfsr[3]);
  end

  // Monitor: sample mid-cycle, pop on handshake
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (stall_seen)  // R6
        check(valid_o && word_o == stall_word, "R6 stall hold", word_o, stall_word);
      stall_seen = valid_o && !ready_i && !start_i;
      stall_word = word_o;
      if (valid_o && ready_i && !start_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 extra word", word_o, 0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          popped++;
          check(word_o == e, "R3 sequence word", word_o, e);
          check(last_o == (exp_q.size() == 0), "R4 last flag", last_o, exp_q.size() == 0);
        end
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_seq(input int k, input bit fast);
    int ke = (k > W) ? W : k;
    logic [W-1:0] first_exp;
    logic [W-1:0] top_exp;
    first_exp = '0;
    for (int i = 0; i < ke; i++) first_exp[i] = 1'b1;
    top_exp = '0;
    for (int i = 0; i < ke; i++) top_exp[W-1-i] = 1'b1;
    full_rate = fast;
    hold = 1'b1;
    push_expected(k);
    check(exp_q[exp_q.size()-1] == top_exp, "R4 reference top word", exp_q[exp_q.size()-1], top_exp);
    popped = 0;
    pulse_start(k);
    @(negedge clk_i);
    check(valid_o && word_o == first_exp, "R1 first word", word_o, first_exp);
    check($countones(word_o) == ke, "R2/R8 weight", $countones(word_o), ke);
    hold = 1'b0;
    while (!done_o) @(negedge clk_i);
    check(popped == binom(W, ke), "R4 word count", popped, binom(W, ke));
    check(!valid_o, "R5 valid low after last", valid_o, 0);
    hold = 1'b1;
    repeat (3) @(negedge clk_i);
    check(done_o && !valid_o, "R5 done held", done_o, 1);
  endtask

  initial begin
    @(negedge clk_i);
    check(!valid_o && !done_o && !last_o && word_o == '0, "R10 in reset", word_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!valid_o && !done_o && !last_o && word_o == '0, "R10 after reset", word_o, 0);

    for (int k = 0; k <= W; k++) run_seq(k, k[0]);  // R7 at k=0 and k=W
    run_seq(W + 5, 1'b0);                           // R8 clamp
    run_seq(2, 1'b1);

    // R9: restart mid-run
    full_rate = 1'b0;
    push_expected(3);
    pulse_start(3);
    hold = 1'b0;
    while (popped < 5) @(negedge clk_i);
    hold = 1'b1;
    repeat (2) @(negedge clk_i);
    check(valid_o && !done_o, "R9 still running", valid_o, 1);
    push_expected(4);
    popped = 0;
    pulse_start(4);
    @(negedge clk_i);
    check(valid_o && word_o == 8'h0F, "R9 restart first word", word_o, 8'h0F);
    hold = 1'b0;
    while (!done_o) @(negedge clk_i);
    check(popped == binom(W, 4), "R9 restart count", popped, binom(W, 4));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule